// File: doc/BRIEF.md
# Single-Scan Queue Trigger Controller

This block decides, for one command queue running a single scan, when the queue may hand commands to a conversion engine. Software picks an operating mode and arms a scan through a register write strobe. The block then watches an external trigger input, which may arrive from any clock domain. It also watches the end-of-scan and hold flags carried by the command now on offer. From these it keeps a triggered state, which gates command flow together with a grant from the arbiter.

The arm bit can only be set by software and can only be cleared by hardware. Hardware clears it when a scan completes or when the mode is set to off. Edge modes latch the triggered state. A hold command suspends that state until the next qualifying edge, and an edge that lands while the queue is still triggered raises a sticky overrun flag. Level-gated modes follow the synchronized input level for as long as the queue is armed. Software mode is triggered by the arm bit alone.

Commands flow with valid/ready. The source raises `cmd_valid` and holds the command and its flags steady until it sees `cmd_ready` high at a rising clock edge. That edge is the transfer. `cmd_ready` is low whenever the queue is not triggered or `grant` is low, and this back-pressure stalls the source.

Top module: `sstrig_ctrl`

## Requirements
- R1: After reset `armed`, `triggered`, `cmd_ready` and `trig_ovr` are all 0, and the mode is off.
- R2: A write (`cfg_we`=1) with `cfg_arm`=1 and an active mode sets `armed` from the next cycle. A write selecting an off mode clears `armed` and keeps it clear while the mode stays off. Only writes can set `armed`.
- R3: While `armed` is 0, no edge or level on `trig_in` makes `triggered` 1 or sets `trig_ovr`.
- R4: A write with `cfg_arm`=1 while `armed` is already 1 changes neither `armed` nor `triggered`, and does not set `trig_ovr`.
- R5: When the mode and the arm bit arrive in one write, both act from the next cycle. A level mode whose active level is already present is then triggered in that next cycle.
- R6: In software mode (`cfg_mode`=1), `triggered` equals `armed`. A transfer with `cmd_eoq`=1 clears `armed`, and `cmd_pause` has no effect.
- R7: In edge modes (2 = rising, 3 = falling, 4 = either), a qualifying edge on `trig_in` while armed sets `triggered`. It is visible after the third rising clock edge following the input change.
- R8: In edge modes, a transfer with `cmd_eoq`=1 clears both `armed` and `triggered`. A transfer with `cmd_pause`=1 clears `triggered` but keeps `armed`, and a later qualifying edge triggers the queue again.
- R9: In edge modes, a qualifying edge while already triggered sets `trig_ovr`. The bit stays set until `ovr_clr`=1 is applied.
- R10: In mode 5 a high synchronized input, and in mode 6 a low one, makes `triggered` equal `armed`. The inactive level drops `triggered` without clearing `armed`. `cmd_pause` is ignored, and `cmd_eoq` on a transfer clears `armed`.
- R11: `cmd_ready` = `triggered` AND `grant`, and a transfer happens only when `cmd_valid` and `cmd_ready` are both 1.
- R12: Mode codes 0 and 7 are off. A write of them with `cfg_arm`=1 leaves `armed` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_mode | input | 3 | Mode to write: 0 off, 1 software, 2 rise, 3 fall, 4 either edge, 5 high gate, 6 low gate, 7 off |
| cfg_arm | input | 1 | Arm request, taken with `cfg_we` |
| ovr_clr | input | 1 | Write-one clear of `trig_ovr` |
| trig_in | input | 1 | Asynchronous trigger input |
| cmd_valid | input | 1 | A command is on offer |
| cmd_eoq | input | 1 | Offered command ends the scan |
| cmd_pause | input | 1 | Offered command requests a hold |
| grant | input | 1 | Queue has top priority and a not-full destination |
| cmd_ready | output | 1 | Command may transfer this cycle |
| triggered | output | 1 | Queue is in the triggered state |
| armed | output | 1 | Scan armed status |
| trig_ovr | output | 1 | Sticky trigger overrun flag |

## Verification
A configuration write takes effect at the clock edge that captures it. `armed` and the software or level `triggered` state can therefore be read in the cycle after that edge, and so can the effect of a hold or end-of-scan transfer. A change on `trig_in` reaches the level gate after two rising edges, while edge-mode `triggered` and `trig_ovr` change only after the third. `cmd_ready` follows `grant` within the same cycle. The bench drives every input just after a falling edge and counts rising edges to each due point. It samples at the following falling edge, and for the edge path it also checks the cycle before the due point to confirm the change has not arrived early.

// File: rtl/sstrig_pkg.sv
package sstrig_pkg;

  typedef enum logic [2:0] {
    MD_OFF  = 3'd0,
    MD_SOFT = 3'd1,
    MD_RISE = 3'd2,
    MD_FALL = 3'd3,
    MD_ANY  = 3'd4,
    MD_HIGH = 3'd5,
    MD_LOW  = 3'd6,
    MD_RSVD = 3'd7
  } scan_mode_e;

  function automatic logic mode_active(input scan_mode_e m);
    return (m != MD_OFF) && (m != MD_RSVD);
  endfunction

  function automatic logic mode_edge(input scan_mode_e m);
    return (m == MD_RISE) || (m == MD_FALL) || (m == MD_ANY);
  endfunction

endpackage

// File: rtl/sstrig_sync.sv
module sstrig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_nxt;
  logic              prev;

  generate
    if (STAGES > 1) begin : g_multi
      assign chain_nxt = {chain[STAGES-2:0], async_in};
    end else begin : g_single
      assign chain_nxt = async_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= chain_nxt;
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/sstrig_arm.sv
module sstrig_arm
  import sstrig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_mode,
  input  logic       cfg_arm,
  input  logic       scan_done,
  output scan_mode_e mode_q,
  output logic       armed_q,
  output logic       mode_chg
);
  scan_mode_e wr_mode;
  logic       armed_d;

  assign wr_mode  = scan_mode_e'(cfg_mode);
  assign mode_chg = cfg_we && (wr_mode != mode_q);

  always_comb begin
    armed_d = armed_q;
    if (cfg_we) begin
      if (!mode_active(wr_mode))   armed_d = 1'b0;
      else if (scan_done)          armed_d = 1'b0;
      else if (cfg_arm)            armed_d = 1'b1;
    end else begin
      if (!mode_active(mode_q))    armed_d = 1'b0;
      else if (scan_done)          armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= MD_OFF;
      armed_q <= 1'b0;
    end else begin
      if (cfg_we) mode_q <= wr_mode;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/sstrig_gate.sv
module sstrig_gate
  import sstrig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  scan_mode_e mode_q,
  input  logic       armed_q,
  input  logic       mode_chg,
  input  logic       lvl,
  input  logic       rise,
  input  logic       fall,
  input  logic       xfer,
  input  logic       cmd_eoq,
  input  logic       cmd_pause,
  input  logic       ovr_clr,
  output logic       triggered,
  output logic       ovr_q
);
  logic edge_sel;
  logic edge_hit;
  logic hold_q;
  logic hold_d;
  logic ovr_d;

  always_comb begin
    unique case (mode_q)
      MD_RISE: edge_sel = rise;
      MD_FALL: edge_sel = fall;
      MD_ANY:  edge_sel = rise | fall;
      default: edge_sel = 1'b0;
    endcase
  end

  assign edge_hit = armed_q && edge_sel;

  always_comb begin
    hold_d = hold_q;
    if (!armed_q || !mode_edge(mode_q) || mode_chg) hold_d = 1'b0;
    else if (xfer && (cmd_eoq || cmd_pause))        hold_d = 1'b0;
    else if (edge_hit)                              hold_d = 1'b1;
  end

  always_comb begin
    ovr_d = ovr_q;
    if (edge_hit && hold_q) ovr_d = 1'b1;
    else if (ovr_clr)       ovr_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    unique case (mode_q)
      MD_SOFT:                 triggered = armed_q;
      MD_RISE, MD_FALL, MD_ANY: triggered = hold_q;
      MD_HIGH:                 triggered = armed_q & lvl;
      MD_LOW:                  triggered = armed_q & ~lvl;
      default:                 triggered = 1'b0;
    endcase
  end
endmodule

// File: rtl/sstrig_ctrl.sv
module sstrig_ctrl
  import sstrig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_mode,
  input  logic       cfg_arm,
  input  logic       ovr_clr,
  input  logic       trig_in,
  input  logic       cmd_valid,
  input  logic       cmd_eoq,
  input  logic       cmd_pause,
  input  logic       grant,
  output logic       cmd_ready,
  output logic       triggered,
  output logic       armed,
  output logic       trig_ovr
);
  scan_mode_e mode_q;
  logic       mode_chg;
  logic       lvl, rise, fall;
  logic       xfer, scan_done;

  assign cmd_ready = triggered & grant;
  assign xfer      = cmd_valid & cmd_ready;
  assign scan_done = xfer & cmd_eoq;

  sstrig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(trig_in),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  sstrig_arm u_arm (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_arm(cfg_arm), .scan_done(scan_done),
    .mode_q(mode_q), .armed_q(armed), .mode_chg(mode_chg)
  );

  sstrig_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .armed_q(armed),
    .mode_chg(mode_chg), .lvl(lvl), .rise(rise), .fall(fall),
    .xfer(xfer), .cmd_eoq(cmd_eoq), .cmd_pause(cmd_pause),
    .ovr_clr(ovr_clr), .triggered(triggered), .ovr_q(trig_ovr)
  );
endmodule

// File: rtl/sstrig_chk.sv
module sstrig_chk
  import sstrig_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_mode,
  input logic       cfg_arm,
  input logic       ovr_clr,
  input logic       cmd_valid,
  input logic       cmd_eoq,
  input logic       grant,
  input logic       cmd_ready,
  input logic       triggered,
  input logic       armed,
  input logic       trig_ovr
);
  logic wr_live;
  logic done_now;

  assign wr_live  = mode_active(scan_mode_e'(cfg_mode));
  assign done_now = cmd_valid && cmd_ready && cmd_eoq;

  AST_READY_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (grant && triggered)); // R11
  AST_TRIG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    triggered |-> armed); // R3
  AST_OFF_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_live) |=> !armed); // R2
  AST_ARM_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_arm && wr_live && !done_now) |=> armed); // R2
  AST_EOQ_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    done_now |=> !armed); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ovr && !ovr_clr) |=> trig_ovr); // R9
  AST_ARM_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(cfg_we && cfg_arm)); // R2
endmodule

bind sstrig_ctrl sstrig_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
  .cfg_arm(cfg_arm), .ovr_clr(ovr_clr), .cmd_valid(cmd_valid),
  .cmd_eoq(cmd_eoq), .grant(grant), .cmd_ready(cmd_ready),
  .triggered(triggered), .armed(armed), .trig_ovr(trig_ovr)
);

// File: tb/test_sstrig_ctrl.sv
`timescale 1ns/1ps
module test_sstrig_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_arm, ovr_clr, trig_in;
  logic [2:0] cfg_mode;
  logic       cmd_valid, cmd_eoq, cmd_pause, grant;
  logic       cmd_ready, triggered, armed, trig_ovr;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  sstrig_ctrl i_sstrig_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_arm(cfg_arm), .ovr_clr(ovr_clr), .trig_in(trig_in),
    .cmd_valid(cmd_valid), .cmd_eoq(cmd_eoq), .cmd_pause(cmd_pause),
    .grant(grant), .cmd_ready(cmd_ready), .triggered(triggered),
    .armed(armed), .trig_ovr(trig_ovr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [2:0] m, input logic a);
    cfg_we = 1'b1; cfg_mode = m; cfg_arm = a;
    tick();
    cfg_we = 1'b0; cfg_arm = 1'b0;
  endtask

  task automatic send(input logic eoq, input logic pause, input logic g);
    cmd_valid = 1'b1; cmd_eoq = eoq; cmd_pause = pause; grant = g;
    tick();
    cmd_valid = 1'b0; cmd_eoq = 1'b0; cmd_pause = 1'b0; grant = 1'b0;
  endtask

  task automatic clr_ovr();
    ovr_clr = 1'b1; tick(); ovr_clr = 1'b0;
    chk("R9 overrun cleared", trig_ovr, 1'b0);
  endtask

  // rise then fall on trig_in; idle level 0 before and after
  task automatic edge_pair(input logic [2:0] m, input logic arm_exp);
    trig_in = 1'b1;
    tick(2);
    chk("R7 no early trigger", triggered, 1'b0);
    tick();
    chk(arm_exp ? "R7 rise" : "R3 rise ignored", triggered,
        arm_exp && (m == 3'd2 || m == 3'd4));
    trig_in = 1'b0;
    tick(3);
    chk(arm_exp ? "R7 fall" : "R3 fall ignored", triggered, arm_exp);
    chk(arm_exp ? "R9 overrun" : "R3 no overrun", trig_ovr, arm_exp && m == 3'd4);
  endtask

  task automatic run_mode(input logic [2:0] m);
    logic live;
    live = (m != 3'd0) && (m != 3'd7);
    trig_in = 1'b0; tick(3);
    wr(m, 1'b0);
    chk("R2 unarmed after plain write", armed, 1'b0);
    trig_in = 1'b1; tick(3);
    chk("R3 level high ignored", triggered, 1'b0);
    trig_in = 1'b0; tick(3);
    chk("R3 level low ignored", triggered, 1'b0);
    chk("R3 no overrun unarmed", trig_ovr, 1'b0);
    wr(m, 1'b1);
    chk("R12 mode code arm", armed, live);
    chk("R5 trigger after arm", triggered, (m == 3'd1) || (m == 3'd6));
    case (m)
      3'd1: begin
        send(1'b0, 1'b1, 1'b1);
        chk("R6 pause ignored armed", armed, 1'b1);
        chk("R6 pause ignored trig", triggered, 1'b1);
        send(1'b1, 1'b0, 1'b0);
        chk("R11 no grant no transfer", armed, 1'b1);
        send(1'b1, 1'b0, 1'b1);
        chk("R6 eoq disarms", armed, 1'b0);
        chk("R6 eoq untriggers", triggered, 1'b0);
      end
      3'd2, 3'd3, 3'd4: begin
        edge_pair(m, 1'b1);
        clr_ovr();
        grant = 1'b1; #1;
        chk("R11 ready with grant", cmd_ready, 1'b1);
        grant = 1'b0; #1;
        chk("R11 not ready without grant", cmd_ready, 1'b0);
        send(1'b0, 1'b1, 1'b1);
        chk("R8 pause untriggers", triggered, 1'b0);
        chk("R8 pause keeps armed", armed, 1'b1);
        edge_pair(m, 1'b1);
        clr_ovr();
        wr(m, 1'b1);
        chk("R4 rearm armed", armed, 1'b1);
        chk("R4 rearm trig", triggered, 1'b1);
        chk("R4 rearm no overrun", trig_ovr, 1'b0);
        send(1'b1, 1'b0, 1'b1);
        chk("R8 eoq disarms", armed, 1'b0);
        chk("R8 eoq untriggers", triggered, 1'b0);
        edge_pair(m, 1'b0);
      end
      3'd5, 3'd6: begin
        trig_in = 1'b1; tick(3);
        chk("R10 gate by level", triggered, m == 3'd5);
        chk("R10 closed gate keeps armed", armed, 1'b1);
        trig_in = (m == 3'd5); tick(3);
        chk("R10 gate open", triggered, 1'b1);
        send(1'b0, 1'b1, 1'b1);
        chk("R10 pause ignored", triggered, 1'b1);
        send(1'b1, 1'b0, 1'b1);
        chk("R10 eoq disarms", armed, 1'b0);
        chk("R10 eoq untriggers", triggered, 1'b0);
        trig_in = 1'b0; tick(3);
      end
      default: ;
    endcase
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = 3'd0; cfg_arm = 1'b0;
    ovr_clr = 1'b0; trig_in = 1'b0; cmd_valid = 1'b0; cmd_eoq = 1'b0;
    cmd_pause = 1'b0; grant = 1'b0;
    tick(3);
    rst_n = 1'b1; grant = 1'b1;
    tick();
    chk("R1 armed", armed, 1'b0);
    chk("R1 triggered", triggered, 1'b0);
    chk("R1 ready", cmd_ready, 1'b0);
    chk("R1 overrun", trig_ovr, 1'b0);
    grant = 1'b0;
    for (int m = 0; m < 8; m++) run_mode(m[2:0]);
    wr(3'd5, 1'b1);
    chk("R2 armed", armed, 1'b1);
    wr(3'd0, 1'b0);
    chk("R2 off disarms", armed, 1'b0);
    tick(2);
    chk("R2 stays clear while off", armed, 1'b0);
    trig_in = 1'b1; tick(3);
    wr(3'd5, 1'b1);
    chk("R5 combined write triggers at once", triggered, 1'b1);
    wr(3'd0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule